// File: doc/BRIEF.md
# Shared DMA Channel Interrupt Status Controller

This block gathers the completion events of up to 32 DMA channels into one interrupt line. Each channel raises a single-cycle done pulse. The block latches that pulse into a raw status register. Software acknowledges an event by writing ones to that register, either one bit at a time or all at once. An enable mask chooses which channels may interrupt. A read-only pending view shows raw status ANDed with the enable mask. A registered, level-sensitive interrupt output is high while any pending bit is set.

A service routine typically reads the pending view, writes zero to the enable mask to drop the line, and acknowledges the channels it serviced. It then writes a new mask. Because capture does not depend on the mask, any event that arrived while the mask was zero shows up again when the mask is restored. One more register holds a single address-width selection bit. That bit is driven out to the channels.

Top module: `dma_irq_status_ctrl`

## Requirements
- R1: After reset, the following all read zero: the raw status, the enable mask, the pending view and the address-mode bit. The interrupt output and the address-width output are also low.
- R2: A done pulse on channel n sets bit n of the raw status at offset 0x080000, whatever the enable mask holds. The bit stays set until it is cleared.
- R3: A write to offset 0x080000 clears each status bit whose write-data bit is 1. Status bits whose write-data bit is 0 are left unchanged.
- R4: Writing 0xFFFFFFFF to offset 0x080000 clears every status bit in one write.
- R5: Offset 0x080004 reads raw status AND enable mask. Writes to this offset change neither the status nor the mask.
- R6: The enable mask at offset 0x080008 can be written and read back. Bits at or above the channel count read as 0.
- R7: The interrupt output is registered. It goes high on the clock edge after the pending view becomes nonzero. It goes low on the clock edge after the pending view becomes zero.
- R8: Writing zero to the enable mask drops the interrupt output and keeps the captured status. Writing the mask again exposes the events that are still outstanding.
- R9: If a done pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R10: Bit 0 of the register at offset 0x000034 is the address-mode bit. Its value of 1 selects 32-bit addressing and drives the address-width output high. The other bits of that register read as 0. Any unmapped offset reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_done | input | NUM_CH | One-cycle completion pulse per channel |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 20 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_out | output | 1 | Level interrupt, registered |
| addr_wide | output | 1 | Address-mode bit (1 = 32-bit addressing) |

## Verification
The bench builds the block with NUM_CH set to 8. This puts the unimplemented upper 24 bits of every register within reach. The bench can show that an all-ones enable write reads back truncated and that an all-ones acknowledge is handled. Eight channels are also enough to acknowledge a pair of bits selectively and to run a same-cycle pulse-and-clear collision on one bit while a neighbouring bit holds. Every interrupt check is sampled both one edge after the status or mask change and one edge later, which pins down the registered latency.

// File: rtl/dmairq_pkg.sv
// Shared constants and types for the DMA interrupt status controller.
// Assumes byte offsets on a 20-bit register address and 32-bit data.
package dmairq_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 20;

    localparam logic [ADDR_W-1:0] OFS_MODE = 20'h00034;
    localparam logic [ADDR_W-1:0] OFS_STAT = 20'h80000;
    localparam logic [ADDR_W-1:0] OFS_PEND = 20'h80004;
    localparam logic [ADDR_W-1:0] OFS_ENAB = 20'h80008;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_PEND,
        SEL_ENAB,
        SEL_MODE
    } reg_sel_e;
endpackage

// File: rtl/dmairq_decode.sv
// Address decoder: maps a register byte offset to a register select.
// Assumes an exact offset match; no aliasing of the upper address bits.
module dmairq_decode
    import dmairq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    // Compare the offset against each register location.
    always_comb begin
        unique case (addr)
            OFS_STAT: sel = SEL_STAT;
            OFS_PEND: sel = SEL_PEND;
            OFS_ENAB: sel = SEL_ENAB;
            OFS_MODE: sel = SEL_MODE;
            default:  sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/dmairq_status_bank.sv
// Raw status bank: one sticky bit per channel.
// A done pulse sets the bit and a masked clear resets it; set beats clear.
// Assumes done pulses are synchronous to clk.
module dmairq_status_bank #(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_i,
    input  logic              clr_en,
    input  logic [NUM_CH-1:0] clr_mask,
    output logic [NUM_CH-1:0] status_o
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
        logic bit_q;
        // Sticky capture with write-one-to-clear; set has priority.
        always_ff @(posedge clk) begin
            if (!rst_n)                      bit_q <= 1'b0;
            else if (set_i[i])               bit_q <= 1'b1;
            else if (clr_en && clr_mask[i])  bit_q <= 1'b0;
        end
        assign status_o[i] = bit_q;
    end
endmodule

// File: rtl/dmairq_cfg.sv
// Configuration registers: the per-channel enable mask and the address-mode bit.
// Assumes write strobes that have already been decoded.
module dmairq_cfg
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_enab,
    input  logic              wr_mode,
    input  logic [DATA_W-1:0] wdata,
    output logic [NUM_CH-1:0] enable_o,
    output logic              mode_o
);
    // Load the enable mask on its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       enable_o <= '0;
        else if (wr_enab) enable_o <= wdata[NUM_CH-1:0];
    end

    // Load the address-mode bit from bit 0 on its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_o <= 1'b0;
        else if (wr_mode) mode_o <= wdata[0];
    end
endmodule

// File: rtl/dmairq_irq_reg.sv
// Interrupt output stage: registers the OR of the pending bits.
// Assumes one cycle of latency is acceptable to the interrupt sink.
module dmairq_irq_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic any_pending,
    output logic irq_q
);
    // Register the level so the output is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= any_pending;
    end
endmodule

// File: rtl/dma_irq_status_ctrl.sv
// Top level of the shared DMA interrupt status controller.
// It captures per-channel done pulses, applies the enable mask, exposes the
// raw status, pending and mask registers on a 32-bit register port, and
// drives one registered level interrupt.
// Assumes NUM_CH is between 1 and 32 and reads have no side effects.
module dma_irq_status_ctrl
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_done,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out,
    output logic              addr_wide
);
    reg_sel_e          sel;
    logic [NUM_CH-1:0] status_q;
    logic [NUM_CH-1:0] enable_q;
    logic [NUM_CH-1:0] pending;

    dmairq_decode u_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    dmairq_status_bank #(.NUM_CH(NUM_CH)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (chan_done),
        .clr_en   (reg_wr_en && sel == SEL_STAT),
        .clr_mask (reg_wdata[NUM_CH-1:0]),
        .status_o (status_q)
    );

    dmairq_cfg #(.NUM_CH(NUM_CH)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_enab  (reg_wr_en && sel == SEL_ENAB),
        .wr_mode  (reg_wr_en && sel == SEL_MODE),
        .wdata    (reg_wdata),
        .enable_o (enable_q),
        .mode_o   (addr_wide)
    );

    assign pending = status_q & enable_q;

    dmairq_irq_reg u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_pending (|pending),
        .irq_q       (irq_out)
    );

    // Read multiplexer: zero-extend the selected register to the port width.
    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_STAT: reg_rdata[NUM_CH-1:0] = status_q;
            SEL_PEND: reg_rdata[NUM_CH-1:0] = pending;
            SEL_ENAB: reg_rdata[NUM_CH-1:0] = enable_q;
            SEL_MODE: reg_rdata[0]          = addr_wide;
            default:  reg_rdata             = '0;
        endcase
    end
endmodule

// File: rtl/dmairq_checker.sv
// Property checker for the DMA interrupt status controller, bound to the top.
// It observes the ports and the status and enable registers.
module dmairq_checker
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] chan_done,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              irq_out,
    input logic [NUM_CH-1:0] status_q,
    input logic [NUM_CH-1:0] enable_q
);
    logic wr_stat, wr_enab;
    assign wr_stat = reg_wr_en && reg_addr == OFS_STAT;
    assign wr_enab = reg_wr_en && reg_addr == OFS_ENAB;

    // R2: without a clearing write, no status bit drops
    p_status_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !wr_stat) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R3: bits cleared by a write and not re-pulsed are zero afterwards
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_stat) |=>
            ((status_q & $past(reg_wdata[NUM_CH-1:0] & ~chan_done)) == '0));

    // R9: every pulsed bit is set on the next cycle, even under a clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && |chan_done) |=> ((status_q & $past(chan_done)) == $past(chan_done)));

    // R6: the mask loads the written value
    p_enable_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_enab) |=> (enable_q == $past(reg_wdata[NUM_CH-1:0])));

    // R8: the mask changes only through its own write
    p_enable_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !wr_enab) |=> $stable(enable_q));

    // R7: the interrupt rises one edge after pending is nonzero
    p_irq_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && |(status_q & enable_q)) |=> irq_out);

    // R7: the interrupt falls one edge after pending is zero
    p_irq_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && (status_q & enable_q) == '0) |=> !irq_out);
endmodule

bind dma_irq_status_ctrl dmairq_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_done (chan_done),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_out   (irq_out),
    .status_q  (status_q),
    .enable_q  (enable_q)
);

// File: tb/dma_irq_status_ctrl_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected items, a monitor pops and compares.
module dma_irq_status_ctrl_bench;
    import dmairq_pkg::*;

    localparam int NCH = 8;
    localparam int K_RD = 0, K_IRQ = 1, K_WIDE = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    chan_done = '0;
    logic              reg_wr_en = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq_out;
    logic              addr_wide;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    dma_irq_status_ctrl #(.NUM_CH(NCH)) u_dma_irq_status_ctrl (
        .clk(clk), .rst_n(rst_n), .chan_done(chan_done),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out), .addr_wide(addr_wide)
    );

    // Monitor: pop expected items and compare them with the outputs.
    initial begin
        forever begin
            wait (sb.size() > 0);
            begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    K_RD:    act = reg_rdata;
                    K_IRQ:   act = {31'b0, irq_out};
                    default: act = {31'b0, addr_wide};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_item(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #0.5;
        expect_item(K_RD, exp, tag);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [NCH-1:0] m);
        chan_done = m;
        tick();
        chan_done = '0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver: stimulus and expected values taken from the requirements.
    initial begin
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        rd(OFS_STAT, 0, "R1 status");
        rd(OFS_ENAB, 0, "R1 enable");
        rd(OFS_PEND, 0, "R1 pending");
        rd(OFS_MODE, 0, "R1 mode");
        expect_item(K_IRQ, 0, "R1 irq");
        expect_item(K_WIDE, 0, "R1 addr_wide");

        // R10 address-mode bit and unmapped reads
        wr(OFS_MODE, 32'h1);
        rd(OFS_MODE, 32'h1, "R10 mode set");
        expect_item(K_WIDE, 1, "R10 addr_wide high");
        wr(OFS_MODE, 32'hFFFF_FFFE);
        rd(OFS_MODE, 32'h0, "R10 mode bit0 only");
        expect_item(K_WIDE, 0, "R10 addr_wide low");
        rd(20'h00010, 32'h0, "R10 unmapped");

        // R6 enable read-back, upper bits read 0
        wr(OFS_ENAB, 32'hFFFF_FFA5);
        rd(OFS_ENAB, 32'h0000_00A5, "R6 enable readback");
        wr(OFS_ENAB, 32'h0);

        // R2 capture regardless of mask
        pulse(8'h05);
        rd(OFS_STAT, 32'h05, "R2 status captured while masked");
        rd(OFS_PEND, 32'h00, "R5 pending masked");
        tick();
        expect_item(K_IRQ, 0, "R8 irq stays low when masked");

        // R5/R7 enable one channel
        wr(OFS_ENAB, 32'h04);
        rd(OFS_PEND, 32'h04, "R5 pending = status & enable");
        expect_item(K_IRQ, 0, "R7 irq not yet high");
        tick();
        expect_item(K_IRQ, 1, "R7 irq high one edge later");

        // R5 writes to pending are ignored
        wr(OFS_PEND, 32'hFF);
        rd(OFS_STAT, 32'h05, "R5 pending write leaves status");
        rd(OFS_ENAB, 32'h04, "R5 pending write leaves enable");

        // R3 selective clear
        wr(OFS_STAT, 32'h04);
        rd(OFS_STAT, 32'h01, "R3 selective clear");
        expect_item(K_IRQ, 1, "R7 irq still high one edge");
        tick();
        expect_item(K_IRQ, 0, "R7 irq low after clear");

        // R9 set beats clear in the same cycle
        chan_done = 8'h02;
        wr(OFS_STAT, 32'h02);
        chan_done = '0;
        rd(OFS_STAT, 32'h03, "R9 set wins over clear");

        // R4 clear all
        pulse(8'hF0);
        rd(OFS_STAT, 32'hF3, "R4 before clear-all");
        wr(OFS_STAT, 32'hFFFF_FFFF);
        rd(OFS_STAT, 32'h00, "R4 clear-all");

        // R8 mask off then re-expose
        wr(OFS_ENAB, 32'hFF);
        pulse(8'h10);
        tick();
        expect_item(K_IRQ, 1, "R8 irq high with mask");
        wr(OFS_ENAB, 32'h0);
        tick();
        expect_item(K_IRQ, 0, "R8 irq dropped by zero mask");
        rd(OFS_STAT, 32'h10, "R8 status retained");
        wr(OFS_ENAB, 32'h10);
        rd(OFS_PEND, 32'h10, "R8 re-exposed pending");
        tick();
        expect_item(K_IRQ, 1, "R8 irq re-asserted");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule